// File: doc/BRIEF.md
# Register-Immediate ALU Execute Stage

This block is the execute step of a small 32-bit RISC pipeline. Each cycle it may accept one decoded instruction image together with the two source register values read for it. It returns, one clock later, the value to write back, the destination register index, a write strobe and the condition flags (carry, overflow, sign, zero), which it keeps in its own flag register.

The block covers these operations:

- addition, in register, 5-bit immediate and 16-bit immediate forms;
- bitwise AND, in register and 16-bit immediate forms;
- compare, in register and 5-bit immediate forms;
- two byte-reordering operations (halfword swap and word swap);
- conditional move, in register and immediate forms.

The block does its own field extraction and its own sign and zero extension. It evaluates the move condition against the flags held when the instruction arrives. The register file, fetch, branching and memory access are outside the block. The surrounding pipeline presents `reg1_val` and `reg2_val` for the indices found in the reg1 and reg2 fields, and it applies the write-back on the cycle that `wb_valid` is high.

Top module: `exu_stage`

## Requirements
- R1: After reset, `wb_valid` is 0 and all four flags (`flag_cy`, `flag_ov`, `flag_s`, `flag_z`) are 0.
- R2: The instruction fields sit at fixed positions:
  - In the first halfword, `insn[15:11]` is reg2, `insn[10:5]` is the opcode and `insn[4:0]` is reg1 or imm5.
  - `insn[31:16]` is the second halfword; it carries imm16, and `insn[31:27]` is reg3.

  Addition works as follows:
  - Opcode 001110 writes reg2 + reg1 into reg2.
  - Opcode 010010 writes reg2 + sign-extended imm5 into reg2.
  - Opcode 110000 writes reg1 + sign-extended imm16 into reg2.

  All additions set CY to the carry out, OV to the signed overflow, S to bit 31 of the result and Z to (result == 0).
- R3: Opcode 001010 writes reg2 AND reg1 into reg2. Opcode 110110 writes reg1 AND zero-extended imm16 into reg2. Both clear OV, set S and Z from the result and leave CY unchanged.
- R4: Opcode 001111 compares reg2 with reg1, and opcode 010011 compares reg2 with sign-extended imm5. A compare forms reg2 minus the operand and sets flags from it: CY is the unsigned borrow, OV the signed overflow, and S and Z come from the difference. No register is written.
- R5: With opcode 111111, reg1 field 0 and `insn[26:16]` = 01101000010, the halfword swap writes reg3 with bytes 23:16, 31:24, 7:0, 15:8 of reg2, most significant first. With `insn[26:16]` = 01101000000, the word swap writes bytes 7:0, 15:8, 23:16, 31:24 of reg2.
- R6: Both swaps clear OV, set CY when any byte of the result is zero, and set S and Z from the result.
- R7: Conditional move uses opcode 111111 with `insn[16]` = 0 and the condition code in `insn[20:17]`.
  - With `insn[26:21]` = 011001, it writes reg1 to reg3 when the condition holds and reg2 otherwise.
  - With `insn[26:21]` = 011000, it writes sign-extended imm5 to reg3 when the condition holds and reg2 otherwise.

  No flag changes.
- R8: Condition codes 0 to 7 are true on the following flag terms, using the flags held before the instruction. Codes 8 to 15 are their negations.

  | Code | True when |
  |------|-----------|
  | 0 | OV |
  | 1 | CY |
  | 2 | Z |
  | 3 | CY or Z |
  | 4 | S |
  | 5 | always |
  | 6 | S xor OV |
  | 7 | (S xor OV) or Z |
- R9: A reg1 or reg2 field of 0 makes that operand read as zero, whatever value is driven on its port. A destination index of 0 never raises `wb_valid`.
- R10: An instruction sampled with `in_valid` high at one rising edge has its write-back and flags visible right after that edge. When `in_valid` is low, `wb_valid` goes low and the flags keep their values.
- R11: Any other encoding leaves `wb_valid` low and the flags unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | An instruction is presented this cycle |
| insn | input | 32 | Instruction image; first halfword in bits 15:0 |
| reg1_val | input | 32 | Value of the register named by the reg1 field |
| reg2_val | input | 32 | Value of the register named by the reg2 field |
| wb_valid | output | 1 | Write-back strobe for this cycle |
| wb_idx | output | 5 | Destination register index |
| wb_data | output | 32 | Write-back value |
| flag_cy | output | 1 | Carry / borrow flag |
| flag_ov | output | 1 | Overflow flag |
| flag_s | output | 1 | Sign flag |
| flag_z | output | 1 | Zero flag |

## Verification
Random operands are drawn from a pool that mixes fully random words with 0, all-ones, the signed extremes and words with a cleared byte:
- The extremes separate carry from overflow in addition and borrow from signed overflow in compare.
- The cleared bytes tell the any-zero-byte carry of the swaps apart from the zero flag.

Immediates are drawn with both sign-bit values, which shows whether sign or zero extension is applied to each form. Every condition code is tried with flag states that make it both true and false. Register 0 is used both as a source holding a nonzero port value and as a destination. Unknown opcodes and idle cycles are interleaved to show that neither touches the flags.

// File: rtl/exu_pkg.sv
package exu_pkg;
  localparam int XLEN   = 32;
  localparam int RIDX   = 5;
  localparam int OPC_W  = 6;
  localparam int IMM_S  = 5;
  localparam int IMM_L  = 16;
  localparam int CC_W   = 4;
  localparam int NBYTES = XLEN / 8;

  // first-halfword opcodes
  localparam logic [OPC_W-1:0] OPC_ADD_RR  = 6'b001110;
  localparam logic [OPC_W-1:0] OPC_ADD_RI5 = 6'b010010;
  localparam logic [OPC_W-1:0] OPC_ADD_I16 = 6'b110000;
  localparam logic [OPC_W-1:0] OPC_AND_RR  = 6'b001010;
  localparam logic [OPC_W-1:0] OPC_AND_I16 = 6'b110110;
  localparam logic [OPC_W-1:0] OPC_CMP_RR  = 6'b001111;
  localparam logic [OPC_W-1:0] OPC_CMP_RI5 = 6'b010011;
  localparam logic [OPC_W-1:0] OPC_EXT     = 6'b111111;
  // second-halfword sub-codes of the extended group
  localparam logic [10:0] SUB_SWAP_H = 11'b01101000010;
  localparam logic [10:0] SUB_SWAP_W = 11'b01101000000;
  localparam logic [5:0]  SUB_SEL_R  = 6'b011001;
  localparam logic [5:0]  SUB_SEL_I  = 6'b011000;

  typedef enum logic [2:0] {
    OP_NONE, OP_ADD, OP_AND, OP_CMP, OP_SWAP_H, OP_SWAP_W, OP_SEL
  } op_e;

  typedef struct packed {
    logic cy;
    logic ov;
    logic s;
    logic z;
  } flags_t;

  function automatic logic [XLEN:0] wide_sum(input logic [XLEN-1:0] a, input logic [XLEN-1:0] b);
    return {1'b0, a} + {1'b0, b};
  endfunction

  function automatic logic sum_ovf(input logic [XLEN-1:0] a, input logic [XLEN-1:0] b,
                                   input logic [XLEN-1:0] r);
    return (a[XLEN-1] == b[XLEN-1]) && (r[XLEN-1] != a[XLEN-1]);
  endfunction

  function automatic logic diff_ovf(input logic [XLEN-1:0] a, input logic [XLEN-1:0] b,
                                    input logic [XLEN-1:0] r);
    return (a[XLEN-1] != b[XLEN-1]) && (r[XLEN-1] != a[XLEN-1]);
  endfunction

  function automatic logic [XLEN-1:0] swap_half(input logic [XLEN-1:0] v);
    return {v[23:16], v[31:24], v[7:0], v[15:8]};
  endfunction

  function automatic logic [XLEN-1:0] swap_word(input logic [XLEN-1:0] v);
    logic [XLEN-1:0] o;
    for (int i = 0; i < NBYTES; i++) o[i*8 +: 8] = v[(NBYTES-1-i)*8 +: 8];
    return o;
  endfunction

  function automatic logic cond_met(input logic [CC_W-1:0] cc, input flags_t f);
    logic base;
    case (cc[2:0])
      3'd0: base = f.ov;
      3'd1: base = f.cy;
      3'd2: base = f.z;
      3'd3: base = f.cy | f.z;
      3'd4: base = f.s;
      3'd5: base = 1'b1;
      3'd6: base = f.s ^ f.ov;
      default: base = (f.s ^ f.ov) | f.z;
    endcase
    return base ^ cc[3];
  endfunction
endpackage

// File: rtl/exu_decode.sv
module exu_decode
  import exu_pkg::*;
#(
  parameter int DW = XLEN,
  parameter int RW = RIDX
) (
  input  logic [DW-1:0]   insn,
  input  logic [DW-1:0]   rv1,
  input  logic [DW-1:0]   rv2,
  output op_e             op,
  output logic [RW-1:0]   dst,
  output logic [DW-1:0]   opa,
  output logic [DW-1:0]   opb,
  output logic [CC_W-1:0] cc
);
  localparam int HW = DW / 2;

  logic [RW-1:0]    f_r1, f_r2, f_r3;
  logic [OPC_W-1:0] f_opc;
  logic [HW-1:0]    f_h2;
  logic [DW-1:0]    v1, v2, imm5_s, imm16_s, imm16_z;

  assign f_r1  = insn[RW-1:0];
  assign f_opc = insn[RW +: OPC_W];
  assign f_r2  = insn[RW+OPC_W +: RW];
  assign f_h2  = insn[DW-1:HW];
  assign f_r3  = f_h2[HW-1 -: RW];
  assign cc    = f_h2[CC_W:1];

  // register 0 reads as zero
  assign v1 = (f_r1 == '0) ? '0 : rv1;
  assign v2 = (f_r2 == '0) ? '0 : rv2;

  assign imm5_s  = {{(DW-IMM_S){f_r1[IMM_S-1]}}, f_r1};
  assign imm16_s = {{(DW-IMM_L){f_h2[IMM_L-1]}}, f_h2};
  assign imm16_z = {{(DW-IMM_L){1'b0}}, f_h2};

  always_comb begin
    op  = OP_NONE;
    dst = f_r2;
    opa = v2;
    opb = v1;
    case (f_opc)
      OPC_ADD_RR:  op = OP_ADD;
      OPC_ADD_RI5: begin op = OP_ADD; opb = imm5_s; end
      OPC_ADD_I16: begin op = OP_ADD; opa = v1; opb = imm16_s; end
      OPC_AND_RR:  op = OP_AND;
      OPC_AND_I16: begin op = OP_AND; opa = v1; opb = imm16_z; end
      OPC_CMP_RR:  op = OP_CMP;
      OPC_CMP_RI5: begin op = OP_CMP; opb = imm5_s; end
      OPC_EXT: begin
        dst = f_r3;
        if (f_r1 == '0 && f_h2[10:0] == SUB_SWAP_H)      op = OP_SWAP_H;
        else if (f_r1 == '0 && f_h2[10:0] == SUB_SWAP_W) op = OP_SWAP_W;
        else if (f_h2[0] == 1'b0 && f_h2[10:5] == SUB_SEL_R) begin
          op = OP_SEL; opa = v1; opb = v2;
        end else if (f_h2[0] == 1'b0 && f_h2[10:5] == SUB_SEL_I) begin
          op = OP_SEL; opa = imm5_s; opb = v2;
        end
      end
      default: op = OP_NONE;
    endcase
  end
endmodule

// File: rtl/exu_cond.sv
module exu_cond
  import exu_pkg::*;
(
  input  logic [CC_W-1:0] cc,
  input  flags_t          flags,
  output logic            met
);
  assign met = cond_met(cc, flags);
endmodule

// File: rtl/exu_alu.sv
module exu_alu
  import exu_pkg::*;
#(
  parameter int DW = XLEN
) (
  input  op_e           op,
  input  logic [DW-1:0] opa,
  input  logic [DW-1:0] opb,
  input  logic          sel_met,
  input  flags_t        flags_in,
  output logic [DW-1:0] res,
  output flags_t        flags_nx,
  output logic          wr_req
);
  localparam int NB = DW / 8;

  logic [DW:0]   sum_w;
  logic [DW-1:0] diff_w, swp;
  logic [NB-1:0] lane_zero;

  assign sum_w  = wide_sum(opa, opb);
  assign diff_w = opa - opb;
  assign swp    = (op == OP_SWAP_H) ? swap_half(opa) : swap_word(opa);

  for (genvar b = 0; b < NB; b++) begin : g_lane
    assign lane_zero[b] = (swp[b*8 +: 8] == 8'h00);
  end

  always_comb begin
    res      = '0;
    flags_nx = flags_in;
    wr_req   = 1'b0;
    case (op)
      OP_ADD: begin
        res      = sum_w[DW-1:0];
        flags_nx = '{cy: sum_w[DW], ov: sum_ovf(opa, opb, sum_w[DW-1:0]),
                     s: sum_w[DW-1], z: (sum_w[DW-1:0] == '0)};
        wr_req   = 1'b1;
      end
      OP_AND: begin
        res         = opa & opb;
        flags_nx.ov = 1'b0;
        flags_nx.s  = res[DW-1];
        flags_nx.z  = (res == '0);
        wr_req      = 1'b1;
      end
      OP_CMP: begin
        res      = diff_w;
        flags_nx = '{cy: (opa < opb), ov: diff_ovf(opa, opb, diff_w),
                     s: diff_w[DW-1], z: (diff_w == '0)};
      end
      OP_SWAP_H, OP_SWAP_W: begin
        res      = swp;
        flags_nx = '{cy: |lane_zero, ov: 1'b0, s: swp[DW-1], z: (swp == '0)};
        wr_req   = 1'b1;
      end
      OP_SEL: begin
        res    = sel_met ? opa : opb;
        wr_req = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/exu_retire.sv
module exu_retire
  import exu_pkg::*;
#(
  parameter int DW = XLEN,
  parameter int RW = RIDX
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          wr_req,
  input  logic [RW-1:0] dst,
  input  logic [DW-1:0] res,
  input  flags_t        flags_nx,
  output logic          wb_valid,
  output logic [RW-1:0] wb_idx,
  output logic [DW-1:0] wb_data,
  output flags_t        flags_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wb_valid <= 1'b0;
      wb_idx   <= '0;
      wb_data  <= '0;
      flags_q  <= '0;
    end else begin
      wb_valid <= in_valid && wr_req && (dst != '0);
      if (in_valid) begin
        wb_idx  <= dst;
        wb_data <= res;
        flags_q <= flags_nx;
      end
    end
  end
endmodule

// File: rtl/exu_stage.sv
module exu_stage
  import exu_pkg::*;
#(
  parameter int DW = XLEN,
  parameter int RW = RIDX
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [DW-1:0] insn,
  input  logic [DW-1:0] reg1_val,
  input  logic [DW-1:0] reg2_val,
  output logic          wb_valid,
  output logic [RW-1:0] wb_idx,
  output logic [DW-1:0] wb_data,
  output logic          flag_cy,
  output logic          flag_ov,
  output logic          flag_s,
  output logic          flag_z
);
  op_e             d_op;
  logic [RW-1:0]   d_dst;
  logic [DW-1:0]   d_opa, d_opb, a_res;
  logic [CC_W-1:0] d_cc;
  logic            c_met, a_wr;
  flags_t          a_flags, flags_q;

  // named events for the checker
  logic ev_cmp, ev_logic, ev_andi, ev_swap, ev_sel, ev_zs, ev_unknown;
  assign ev_cmp     = in_valid && (d_op == OP_CMP);
  assign ev_logic   = in_valid && (d_op == OP_AND);
  assign ev_andi    = in_valid && (insn[RW +: OPC_W] == OPC_AND_I16);
  assign ev_swap    = in_valid && (d_op == OP_SWAP_H || d_op == OP_SWAP_W);
  assign ev_sel     = in_valid && (d_op == OP_SEL);
  assign ev_zs      = in_valid && (d_op == OP_ADD || d_op == OP_AND ||
                                   d_op == OP_SWAP_H || d_op == OP_SWAP_W);
  assign ev_unknown = in_valid && (d_op == OP_NONE);

  exu_decode #(.DW(DW), .RW(RW)) u_dec (
    .insn(insn), .rv1(reg1_val), .rv2(reg2_val),
    .op(d_op), .dst(d_dst), .opa(d_opa), .opb(d_opb), .cc(d_cc)
  );

  exu_cond u_cond (.cc(d_cc), .flags(flags_q), .met(c_met));

  exu_alu #(.DW(DW)) u_alu (
    .op(d_op), .opa(d_opa), .opb(d_opb), .sel_met(c_met), .flags_in(flags_q),
    .res(a_res), .flags_nx(a_flags), .wr_req(a_wr)
  );

  exu_retire #(.DW(DW), .RW(RW)) u_ret (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .wr_req(a_wr), .dst(d_dst),
    .res(a_res), .flags_nx(a_flags), .wb_valid(wb_valid), .wb_idx(wb_idx),
    .wb_data(wb_data), .flags_q(flags_q)
  );

  assign flag_cy = flags_q.cy;
  assign flag_ov = flags_q.ov;
  assign flag_s  = flags_q.s;
  assign flag_z  = flags_q.z;
endmodule

// File: rtl/exu_stage_chk.sv
module exu_stage_chk #(
  parameter int DW = 32,
  parameter int RW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          wb_valid,
  input logic [RW-1:0] wb_idx,
  input logic [DW-1:0] wb_data,
  input logic          flag_cy,
  input logic          flag_ov,
  input logic          flag_s,
  input logic          flag_z,
  input logic          ev_cmp,
  input logic          ev_logic,
  input logic          ev_andi,
  input logic          ev_swap,
  input logic          ev_sel,
  input logic          ev_zs,
  input logic          ev_unknown
);
  a_r9_zero_dest_silent: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> wb_idx != '0);

  a_r4_compare_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    ev_cmp |=> !wb_valid);

  a_r3_logic_ov_clear: assert property (@(posedge clk) disable iff (!rst_n)
    ev_logic |=> !flag_ov);

  a_r3_andi_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ev_andi |=> wb_data[DW-1:DW/2] == '0);

  a_r6_swap_ov_clear: assert property (@(posedge clk) disable iff (!rst_n)
    ev_swap |=> !flag_ov);

  a_r7_select_flags_kept: assert property (@(posedge clk) disable iff (!rst_n)
    ev_sel |=> $stable({flag_cy, flag_ov, flag_s, flag_z}));

  a_r2_zs_follow_result: assert property (@(posedge clk) disable iff (!rst_n)
    ev_zs |=> (flag_z == (wb_data == '0)) && (flag_s == wb_data[DW-1]));

  a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !wb_valid && $stable({flag_cy, flag_ov, flag_s, flag_z}));

  a_r11_unknown_inert: assert property (@(posedge clk) disable iff (!rst_n)
    ev_unknown |=> !wb_valid && $stable({flag_cy, flag_ov, flag_s, flag_z}));
endmodule

bind exu_stage exu_stage_chk #(.DW(DW), .RW(RW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .wb_valid(wb_valid),
  .wb_idx(wb_idx), .wb_data(wb_data), .flag_cy(flag_cy), .flag_ov(flag_ov),
  .flag_s(flag_s), .flag_z(flag_z), .ev_cmp(ev_cmp), .ev_logic(ev_logic),
  .ev_andi(ev_andi), .ev_swap(ev_swap), .ev_sel(ev_sel), .ev_zs(ev_zs),
  .ev_unknown(ev_unknown)
);

// File: tb/sim_exu_stage.sv
`timescale 1ns/1ps
module sim_exu_stage;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] insn = '0, reg1_val = '0, reg2_val = '0;
  logic        wb_valid;
  logic [4:0]  wb_idx;
  logic [31:0] wb_data;
  logic        flag_cy, flag_ov, flag_s, flag_z;

  int n_cmp = 0;
  int n_bad = 0;
  logic [3:0] mflags = 4'b0000; // {cy, ov, s, z}

  always #2.5 clk = ~clk;

  exu_stage u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .insn(insn),
    .reg1_val(reg1_val), .reg2_val(reg2_val), .wb_valid(wb_valid),
    .wb_idx(wb_idx), .wb_data(wb_data), .flag_cy(flag_cy), .flag_ov(flag_ov),
    .flag_s(flag_s), .flag_z(flag_z)
  );

  task automatic chk(input string tag, input string what, input logic [63:0] got,
                     input logic [63:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, got, exp);
    end
  endtask

  function automatic bit tb_cond(input logic [3:0] c, input logic [3:0] f);
    bit cy, ov, s, z;
    {cy, ov, s, z} = f;
    case (c)
      4'd0: return ov;             4'd8:  return !ov;
      4'd1: return cy;             4'd9:  return !cy;
      4'd2: return z;              4'd10: return !z;
      4'd3: return cy || z;        4'd11: return !(cy || z);
      4'd4: return s;              4'd12: return !s;
      4'd5: return 1'b1;           4'd13: return 1'b0;
      4'd6: return s != ov;        4'd14: return s == ov;
      4'd7: return (s != ov) || z; default: return !((s != ov) || z);
    endcase
  endfunction

  task automatic model(input logic [31:0] ins, input logic [31:0] v1, input logic [31:0] v2,
                       input logic [3:0] fin, output bit we, output logic [4:0] idx,
                       output logic [31:0] dat, output logic [3:0] fout, output string tag);
    logic [4:0]  r1, r2;
    logic [5:0]  opc;
    logic [15:0] h;
    logic [31:0] a1, a2, s5, s16, z16, x, y;
    logic [32:0] w;
    int kind;
    r1 = ins[4:0]; opc = ins[10:5]; r2 = ins[15:11]; h = ins[31:16];
    a1 = (r1 == 0) ? 32'd0 : v1;
    a2 = (r2 == 0) ? 32'd0 : v2;
    s5 = {{27{r1[4]}}, r1}; s16 = {{16{h[15]}}, h}; z16 = {16'd0, h};
    kind = 0; x = 0; y = 0; idx = r2; tag = "R11";
    case (opc)
      6'b001110: begin kind = 1; x = a2; y = a1;  tag = "R2"; end
      6'b010010: begin kind = 1; x = a2; y = s5;  tag = "R2"; end
      6'b110000: begin kind = 1; x = a1; y = s16; tag = "R2"; end
      6'b001010: begin kind = 2; x = a2; y = a1;  tag = "R3"; end
      6'b110110: begin kind = 2; x = a1; y = z16; tag = "R3"; end
      6'b001111: begin kind = 3; x = a2; y = a1;  tag = "R4"; end
      6'b010011: begin kind = 3; x = a2; y = s5;  tag = "R4"; end
      6'b111111: begin
        idx = ins[31:27];
        if (r1 == 0 && h[10:0] == 11'b01101000010) begin kind = 4; x = a2; tag = "R5"; end
        else if (r1 == 0 && h[10:0] == 11'b01101000000) begin kind = 5; x = a2; tag = "R5"; end
        else if (h[0] == 0 && h[10:5] == 6'b011001) begin kind = 6; x = a1; y = a2; tag = "R7"; end
        else if (h[0] == 0 && h[10:5] == 6'b011000) begin kind = 6; x = s5; y = a2; tag = "R7"; end
      end
      default: kind = 0;
    endcase
    we = 0; dat = 0; fout = fin;
    case (kind)
      1: begin
        w = {1'b0, x} + {1'b0, y}; dat = w[31:0]; we = 1;
        fout = {w[32], (x[31] == y[31]) && (dat[31] != x[31]), dat[31], dat == 0};
      end
      2: begin dat = x & y; we = 1; fout = {fin[3], 1'b0, dat[31], dat == 0}; end
      3: begin
        dat = x - y;
        fout = {x < y, (x[31] != y[31]) && (dat[31] != x[31]), dat[31], dat == 0};
      end
      4, 5: begin
        dat = (kind == 4) ? {x[23:16], x[31:24], x[7:0], x[15:8]}
                          : {x[7:0], x[15:8], x[23:16], x[31:24]};
        we = 1;
        fout = {(dat[7:0] == 0) || (dat[15:8] == 0) || (dat[23:16] == 0) || (dat[31:24] == 0),
                1'b0, dat[31], dat == 0};
      end
      6: begin dat = tb_cond(h[4:1], fin) ? x : y; we = 1; end
      default: ;
    endcase
    we = we && (idx != 0);
  endtask

  task automatic step(input bit vld, input logic [31:0] ins, input logic [31:0] v1,
                      input logic [31:0] v2, input string tag_over);
    bit we; logic [4:0] idx; logic [31:0] dat; logic [3:0] fo; string tag;
    @(negedge clk);
    in_valid = vld; insn = ins; reg1_val = v1; reg2_val = v2;
    if (vld) model(ins, v1, v2, mflags, we, idx, dat, fo, tag);
    else begin we = 0; idx = 0; dat = 0; fo = mflags; tag = "R10"; end
    if (tag_over != "") tag = tag_over;
    @(posedge clk); #1;
    chk(tag, "wb_valid", 64'(wb_valid), 64'(we));
    if (we) begin
      chk(tag, "wb_idx", 64'(wb_idx), 64'(idx));
      chk(tag, "wb_data", 64'(wb_data), 64'(dat));
    end
    chk(tag, "flags", 64'({flag_cy, flag_ov, flag_s, flag_z}), 64'(fo));
    mflags = fo;
    in_valid = 1'b0;
  endtask

  function automatic logic [31:0] i16(input logic [5:0] o, input logic [4:0] r2, input logic [4:0] r1,
                                      input logic [15:0] hi);
    return {hi, r2, o, r1};
  endfunction

  function automatic logic [31:0] pick_val();
    logic [31:0] v;
    case ($urandom_range(0, 7))
      0: v = 32'h0;
      1: v = 32'hFFFF_FFFF;
      2: v = 32'h8000_0000;
      3: v = 32'h7FFF_FFFF;
      4: begin v = $urandom; v[8*$urandom_range(0, 3) +: 8] = 8'h00; end
      default: v = $urandom;
    endcase
    return v;
  endfunction

  function automatic logic [31:0] pick_insn();
    logic [4:0] r1, r2, r3; logic [15:0] hi; logic [3:0] cc;
    r1 = 5'($urandom); r2 = 5'($urandom); r3 = 5'($urandom);
    hi = 16'($urandom); cc = 4'($urandom);
    case ($urandom_range(0, 11))
      0:  return i16(6'b001110, r2, r1, hi);
      1:  return i16(6'b010010, r2, r1, hi);
      2:  return i16(6'b110000, r2, r1, hi);
      3:  return i16(6'b001010, r2, r1, hi);
      4:  return i16(6'b110110, r2, r1, hi);
      5:  return i16(6'b001111, r2, r1, hi);
      6:  return i16(6'b010011, r2, r1, hi);
      7:  return i16(6'b111111, r2, 5'd0, {r3, 11'b01101000010});
      8:  return i16(6'b111111, r2, 5'd0, {r3, 11'b01101000000});
      9:  return i16(6'b111111, r2, r1, {r3, 6'b011001, cc, 1'b0});
      10: return i16(6'b111111, r2, r1, {r3, 6'b011000, cc, 1'b0});
      default: return i16(6'($urandom), r2, r1, hi);
    endcase
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1", "wb_valid", 64'(wb_valid), 64'd0);
    chk("R1", "flags", 64'({flag_cy, flag_ov, flag_s, flag_z}), 64'd0);
    @(negedge clk); rst_n = 1'b1;

    // R2 carry and overflow corners
    step(1, i16(6'b001110, 5'd3, 5'd4, 16'h0), 32'h0000_0001, 32'h7FFF_FFFF, "R2");
    step(1, i16(6'b001110, 5'd3, 5'd4, 16'h0), 32'h0000_0001, 32'hFFFF_FFFF, "R2");
    step(1, i16(6'b010010, 5'd6, 5'b10000, 16'h0), 32'h0, 32'h0000_0010, "R2");
    step(1, i16(6'b110000, 5'd7, 5'd8, 16'h8000), 32'h0000_8000, 32'h0, "R2");
    // R3 zero-extended immediate, CY kept
    step(1, i16(6'b110110, 5'd9, 5'd10, 16'hF0F0), 32'hFFFF_FFFF, 32'h0, "R3");
    // R4 equal and borrow compares
    step(1, i16(6'b001111, 5'd2, 5'd5, 16'h0), 32'h1234_5678, 32'h1234_5678, "R4");
    step(1, i16(6'b010011, 5'd2, 5'b11111, 16'h0), 32'h0, 32'h0000_0001, "R4");
    // R5 byte orders, R6 zero-byte carry
    step(1, i16(6'b111111, 5'd11, 5'd0, {5'd12, 11'b01101000010}), 32'h0, 32'h1122_3344, "R5");
    step(1, i16(6'b111111, 5'd11, 5'd0, {5'd12, 11'b01101000000}), 32'h0, 32'h1122_3344, "R5");
    step(1, i16(6'b111111, 5'd11, 5'd0, {5'd12, 11'b01101000000}), 32'h0, 32'h1100_3344, "R6");
    step(1, i16(6'b111111, 5'd11, 5'd0, {5'd12, 11'b01101000010}), 32'h0, 32'h0, "R6");
    // R8 every condition code under two flag states
    for (int st = 0; st < 2; st++) begin
      if (st == 0) step(1, i16(6'b001111, 5'd2, 5'd5, 16'h0), 32'h1, 32'h1, "R4");
      else         step(1, i16(6'b001110, 5'd2, 5'd5, 16'h0), 32'h1, 32'h7FFF_FFFF, "R2");
      for (int c = 0; c < 16; c++)
        step(1, i16(6'b111111, 5'd13, 5'd14, {5'd15, 6'b011001, 4'(c), 1'b0}),
             32'hAAAA_0001, 32'h5555_0002, "R8");
    end
    step(1, i16(6'b111111, 5'd13, 5'b10101, {5'd15, 6'b011000, 4'd5, 1'b0}), 32'h0, 32'h9, "R7");
    // R9 register 0 as source and destination
    step(1, i16(6'b001110, 5'd0, 5'd4, 16'h0), 32'h5, 32'h77, "R9");
    step(1, i16(6'b001110, 5'd3, 5'd0, 16'h0), 32'hDEAD_BEEF, 32'h10, "R9");
    step(1, i16(6'b111111, 5'd0, 5'd0, {5'd1, 11'b01101000000}), 32'h1, 32'h1234_5678, "R9");
    // R10 idle, R11 unknown opcode
    step(0, i16(6'b001110, 5'd3, 5'd4, 16'h0), 32'h1, 32'h1, "R10");
    step(1, i16(6'b000000, 5'd3, 5'd4, 16'h0), 32'h1, 32'h1, "R11");
    step(1, i16(6'b111111, 5'd3, 5'd4, {5'd3, 11'b01101000010}), 32'h1, 32'h1, "R11");

    for (int n = 0; n < 4000; n++)
      step($urandom_range(0, 9) != 0, pick_insn(), pick_val(), pick_val(), "");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule